// File: doc/BRIEF.md
# One-Shot Interval Timer

This block is a byte-programmed down-counter that raises a single interrupt flag for each time it is started. Software first writes the low byte of the start value, which is only held in a latch. Writing the high byte then copies the high byte and the latched low byte into the counter, arms the timer and clears any pending flag. From the following cycle on, the counter steps down by one on every cycle in which the count-enable input is high.

When an armed counter steps from zero to all ones, the flag rises and the timer disarms. The counter does not reload. It keeps wrapping downward, and later passes through zero do not raise the flag again until the high byte is written once more. The counter can be read back a byte at a time. Reading the low byte also clears the flag, so a service routine can acknowledge the interrupt and measure the time elapsed since it fired in a single access.

Top module: `oneshot_timer`

## Requirements
- R1: A write with `sel`=0 stores `wdata` in the low latch and leaves the counter value unchanged.
- R2: A write with `sel`=1 loads the counter with {`wdata`, low latch}, arms the timer and clears `irq`. All of this is visible after that clock edge.
- R3: When no load takes place, the counter decrements by one, modulo 2^16, on each edge where `tick` is 1, and holds its value when `tick` is 0.
- R4: `irq` rises on the edge where an armed counter passes from 0 to 0xFFFF. After a load with value N and `tick` held high, this is the (N+1)-th edge after the load edge.
- R5: After firing, the counter keeps wrapping down without reloading, and `irq` is not set again by any later pass through zero until the next high-byte write.
- R6: `rdata` shows the counter low byte when `sel`=0 and the high byte when `sel`=1, combinationally. A read (`rd_en`=1) with `sel`=0 clears `irq`. A read with `sel`=1 leaves `irq` unchanged.
- R7: When the timer fires on the same edge as a low-byte read, `irq` is set.
- R8: Synchronous active-low reset clears `irq` and disarms the timer. It leaves the counter and the low latch unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| sel | input | 1 | Byte select: 0 low byte, 1 high byte |
| wdata | input | 8 | Write data |
| tick | input | 1 | Count enable, one decrement per enabled cycle |
| rdata | output | 8 | Selected counter byte |
| irq | output | 1 | Timer interrupt flag |

## Verification
A counter that skips or doubles a step shows up at once in the byte readback, because the bench compares both bytes against its own model after every edge. A wrong armed state shows up only at the next pass through zero: as a missing flag on the (N+1)-th tick, or as a second flag about 65536 ticks after the first one. For that reason the bench runs one full wrap after firing and one after a reset. Flag clearing and its priority against firing are visible on the next edge.

// File: rtl/oneshot_timer_pkg.sv
// Shared definitions for the one-shot interval timer.
// Assumes a two-register byte map selected by a single select bit.
package oneshot_timer_pkg;
    localparam logic SEL_LO = 1'b0;
    localparam logic SEL_HI = 1'b1;

    // Decoded access strobes for one cycle
    typedef struct packed {
        logic load;   // high-byte write: load and arm
        logic wr_lo;  // low-latch write
        logic rd_lo;  // low-byte read: flag acknowledge
    } ost_ctl_t;
endpackage

// File: rtl/ost_regif.sv
// Register interface: decodes the byte accesses and holds the low latch.
// Assumes that wr_en and rd_en are single-cycle strobes. The latch has no reset.
module ost_regif
    import oneshot_timer_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             sel,
    input  logic [BUS_W-1:0] wdata,
    output ost_ctl_t         ctl,
    output logic [BUS_W-1:0] lo_q
);
    // Decode the strobes against the byte select
    always_comb begin
        ctl.load  = wr_en && (sel == SEL_HI);
        ctl.wr_lo = wr_en && (sel == SEL_LO);
        ctl.rd_lo = rd_en && (sel == SEL_LO);
    end

    // Capture the low latch byte
    always_ff @(posedge clk) begin
        if (ctl.wr_lo) lo_q <= wdata;
    end
endmodule

// File: rtl/ost_counter.sv
// Down-counter: loads on request, otherwise decrements on each enabled cycle.
// Assumes that a load takes priority over counting. It has no reset, so it keeps its value through reset.
module ost_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             load,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             at_zero
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Load or step the count downward, wrapping through all ones
    always_ff @(posedge clk) begin
        if (load)      cnt_q <= load_val;
        else if (tick) cnt_q <= cnt_q - ONE;
    end

    // Flag the value from which the next step wraps
    always_comb at_zero = (cnt_q == '0);
endmodule

// File: rtl/ost_flag.sv
// Arm and flag control: one flag per load, acknowledged by a low-byte read.
// Assumes that at_zero and tick refer to the current counter value. Firing beats the acknowledge.
module ost_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    input  logic at_zero,
    input  logic rd_lo,
    output logic armed_q,
    output logic flag_q
);
    logic fire;

    // Detect the zero-to-all-ones step of an armed counter
    always_comb fire = armed_q && tick && at_zero && !load;

    // Sequence the arm and flag state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            flag_q  <= 1'b0;
        end else if (load) begin
            armed_q <= 1'b1;
            flag_q  <= 1'b0;
        end else if (fire) begin
            armed_q <= 1'b0;
            flag_q  <= 1'b1;
        end else if (rd_lo) begin
            flag_q  <= 1'b0;
        end
    end
endmodule

// File: rtl/oneshot_timer.sv
// Top of the one-shot interval timer: a byte-wide register port over a
// double-byte down-counter. It raises one interrupt flag per high-byte write.
// Assumes that the counter width is twice the bus width.
module oneshot_timer
    import oneshot_timer_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             sel,
    input  logic [BUS_W-1:0] wdata,
    input  logic             tick,
    output logic [BUS_W-1:0] rdata,
    output logic             irq
);
    localparam int CNT_W = 2 * BUS_W;

    ost_ctl_t         ctl;
    logic [BUS_W-1:0] lo_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;
    logic             armed_q;

    ost_regif #(.BUS_W(BUS_W)) u_regif (
        .clk   (clk),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .sel   (sel),
        .wdata (wdata),
        .ctl   (ctl),
        .lo_q  (lo_q)
    );

    ost_counter #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .load     (ctl.load),
        .tick     (tick),
        .load_val ({wdata, lo_q}),
        .cnt_q    (cnt_q),
        .at_zero  (at_zero)
    );

    ost_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ctl.load),
        .tick    (tick),
        .at_zero (at_zero),
        .rd_lo   (ctl.rd_lo),
        .armed_q (armed_q),
        .flag_q  (irq)
    );

    // Select the counter byte for readback
    always_comb rdata = (sel == SEL_HI) ? cnt_q[CNT_W-1:BUS_W] : cnt_q[BUS_W-1:0];
endmodule

// File: rtl/oneshot_timer_chk.sv
// Property checker for the one-shot interval timer, bound to the top module.
module oneshot_timer_chk #(
    parameter int BUS_W = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             sel,
    input logic [BUS_W-1:0] wdata,
    input logic             tick,
    input logic             irq,
    input logic [BUS_W-1:0] lo_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             armed_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R1
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel) |=> (lo_q == $past(wdata)));

    // R2
    load_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel) |=> (cnt_q == {$past(wdata), $past(lo_q)}) && armed_q && !irq);

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && sel) && tick) |=> (cnt_q == $past(cnt_q) - ONE));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && sel) && !tick) |=> $stable(cnt_q));

    // R4
    fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && tick && (cnt_q == '0) && !(wr_en && sel)) |=> (irq && !armed_q));

    // R5
    single_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(armed_q));

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !sel && !wr_en && !(armed_q && tick && (cnt_q == '0))) |=> !irq);

    // R6
    high_read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && rd_en && sel && !wr_en) |=> irq);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq && !armed_q));
endmodule

bind oneshot_timer oneshot_timer_chk #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .sel     (sel),
    .wdata   (wdata),
    .tick    (tick),
    .irq     (irq),
    .lo_q    (lo_q),
    .cnt_q   (cnt_q),
    .armed_q (armed_q)
);

// File: tb/oneshot_timer_test.sv
module oneshot_timer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       sel = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       tick = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    logic [15:0] m_cnt = 16'h0;
    logic [7:0]  m_lo = 8'h0;
    bit          m_arm = 0;
    bit          m_flag = 0;
    bit          m_lo_known = 0;
    bit          m_known = 0;

    oneshot_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
        .wdata(wdata), .tick(tick), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model, advanced at every rising edge
    always @(posedge clk) begin
        bit ld, fr;
        ld = wr_en && sel;
        fr = m_arm && tick && (m_cnt == 16'h0) && !ld;
        if (ld) begin
            m_cnt = {wdata, m_lo};
            if (m_lo_known) m_known = 1;
        end else if (tick) begin
            m_cnt = m_cnt - 16'h1;
        end
        if (wr_en && !sel) begin
            m_lo = wdata;
            m_lo_known = 1;
        end
        if (!rst_n) begin
            m_arm = 0; m_flag = 0;
        end else if (ld) begin
            m_arm = 1; m_flag = 0;
        end else if (fr) begin
            m_arm = 0; m_flag = 1;
        end else if (rd_en && !sel) begin
            m_flag = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic peek(input logic s, output logic [7:0] v);
        sel = s;
        #1;
        v = rdata;
    endtask

    // one clock: apply inputs, pass the edge, compare against the model
    task automatic cyc(input logic w, input logic r, input logic s,
                       input logic [7:0] d, input logic t);
        logic [7:0] lo, hi;
        wr_en = w; rd_en = r; sel = s; wdata = d; tick = t;
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; rd_en = 0; tick = 0;
        chk("R4/R6 model irq", int'(irq), int'(m_flag));
        if (m_known) begin
            peek(1'b0, lo);
            peek(1'b1, hi);
            chk("R3 model count", int'({hi, lo}), int'(m_cnt));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        finish_run();
    end

    initial begin
        logic [7:0] v, v2;
        @(negedge clk);
        rst_n = 0;
        cyc(0, 0, 0, 8'h00, 0);
        cyc(0, 0, 0, 8'h00, 0);
        chk("R8 reset irq", int'(irq), 0);
        rst_n = 1;

        // R1: a low write only touches the latch
        cyc(1, 0, 0, 8'h77, 0);
        cyc(1, 0, 1, 8'h00, 0);            // count 0x0077
        cyc(1, 0, 0, 8'h05, 0);
        peek(1'b0, v);
        chk("R1 counter unchanged by low write", int'(v), 8'h77);
        // R2: the high write loads {data, latch}
        cyc(1, 0, 1, 8'h00, 0);
        peek(1'b0, v); peek(1'b1, v2);
        chk("R2 load value", int'({v2, v}), 16'h0005);
        chk("R2 flag clear after load", int'(irq), 0);
        // R3: holds without tick
        cyc(0, 0, 0, 8'h00, 0);
        peek(1'b0, v);
        chk("R3 hold without tick", int'(v), 8'h05);

        // R4: fires on the sixth tick for N=5
        for (int k = 1; k <= 6; k++) begin
            cyc(0, 0, 0, 8'h00, 1);
            if (k == 5) chk("R4 no flag at zero", int'(irq), 0);
        end
        chk("R4 flag after N+1 ticks", int'(irq), 1);
        peek(1'b0, v); peek(1'b1, v2);
        chk("R4 wrap to all ones", int'({v2, v}), 16'hFFFF);

        // R5: keeps counting down without reload
        cyc(0, 0, 0, 8'h00, 1);
        peek(1'b0, v);
        chk("R5 continues down", int'(v), 8'hFE);
        // R6: a high read keeps the flag, a low read clears it
        cyc(0, 1, 1, 8'h00, 0);
        chk("R6 high read keeps flag", int'(irq), 1);
        cyc(0, 1, 0, 8'h00, 0);
        chk("R6 low read clears flag", int'(irq), 0);
        // R5: a full wrap does not fire again
        for (int k = 0; k < 65534; k++) cyc(0, 0, 0, 8'h00, 1);
        peek(1'b0, v); peek(1'b1, v2);
        chk("R5 back at zero", int'({v2, v}), 0);
        cyc(0, 0, 0, 8'h00, 1);
        chk("R5 no second flag", int'(irq), 0);

        // R7: firing beats the low-read clear
        cyc(1, 0, 0, 8'h00, 0);
        cyc(1, 0, 1, 8'h00, 0);
        cyc(0, 1, 0, 8'h00, 1);
        chk("R7 fire wins over read", int'(irq), 1);
        // R2: a high write clears a pending flag
        cyc(1, 0, 1, 8'h01, 0);
        chk("R2 load clears flag", int'(irq), 0);
        peek(1'b1, v);
        chk("R2 high byte loaded", int'(v), 8'h01);

        // R8: reset keeps the counter and latch, clears the flag and disarms
        cyc(1, 0, 0, 8'h3C, 0);
        rst_n = 0;
        cyc(0, 0, 0, 8'h00, 0);
        rst_n = 1;
        chk("R8 flag low after reset", int'(irq), 0);
        peek(1'b0, v); peek(1'b1, v2);
        chk("R8 counter kept", int'({v2, v}), 16'h0100);
        for (int k = 0; k < 257; k++) cyc(0, 0, 0, 8'h00, 1);
        chk("R8 disarmed by reset", int'(irq), 0);
        cyc(1, 0, 1, 8'h02, 0);
        peek(1'b0, v); peek(1'b1, v2);
        chk("R8 latch kept", int'({v2, v}), 16'h023C);

        finish_run();
    end
endmodule